// File: doc/BRIEF.md
# Interrupt Flag Controller

This block gathers event and condition inputs from a set of peripheral sources into sticky flag bits, each gated by its own enable bit. When the global interrupt-enable bit is set and at least one flag is both set and enabled, the block raises a request to the CPU and presents the index of the lowest-numbered such source. When the CPU acknowledges, the global enable drops at once. For ordinary sources, the flag of the taken source also clears. A return-from-handler input sets the global enable again.

Every source has one of three kinds, chosen by parameter. An ordinary source sets its flag on a one-cycle pulse, and both acknowledge and software can clear that flag. A manual source sets the same way but ignores acknowledge, so only a software clear removes its flag. A level source copies its input condition every cycle, so its flag stays set until the condition goes away.

Software sees three registers through a small synchronous write port and a combinational read port. Flag bits are cleared by writing 1 and left alone by writing 0. A read-modify-write of the flag register therefore clears every flag that was read as set.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the flag, enable-mask and global-enable registers read 0 and `irq_req` is low.
- R2: A 1 on `src_in[i]` of a pulse or manual source sets flag i on the next clock edge. If a software clear of the same bit lands in the same cycle, the set takes priority and the flag ends up set.
- R3: A write to address 0 clears each pulse or manual flag whose `reg_wdata` bit is 1. Flags whose `reg_wdata` bit is 0 keep their value.
- R4: Writing the flag register's own read value back to address 0 clears every pulse-type or manual flag that was read as 1.
- R5: `irq_req` is 1 exactly when the global enable is 1 and some bit is set in both the flags and the mask. While it is 1, `irq_vec` is the lowest such bit index.
- R6: An acknowledge (`irq_ack` high while `irq_req` is high) clears the global enable on the same edge. `irq_req` then stays low until the global enable is set again. `irq_ack` with `irq_req` low has no effect.
- R7: An acknowledge clears the taken flag of a pulse-type source. A manual source (bit set in MANUAL_SRC) keeps its flag through an acknowledge.
- R8: A level source (bit set in LEVEL_SRC) has a flag equal to its input one cycle earlier. Neither a write-1 clear nor an acknowledge changes it.
- R9: `irq_ret` sets the global enable on the next edge. An acknowledge in the same cycle takes priority and leaves it 0. With neither present, a write to address 2 loads `reg_wdata[0]` into it.
- R10: Address map: 0 is the flags, 1 is the mask (a plain write), and 2 is the global enable in bit 0, with all other bits reading 0. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NSRC | Source set pulses or level conditions |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | VW | Index of the source being requested |
| irq_ack | input | 1 | CPU takes the vector |
| irq_ret | input | 1 | Return from handler, sets the global enable |

## Verification
The bench uses the default build: eight sources, with source 6 as a manual source and source 7 as a level source. This gives one instance of each source kind, so the tests can check that acknowledge clears some flags and exempts others, and that write-1 clears cannot remove a level flag while its condition is still present. Because there are eight sources, the priority pick is exercised across a full byte, including cases where several sources are pending at once and a low index must win over higher ones.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_MASK = 2'd1,
    RA_CTRL = 2'd2,
    RA_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SK_PULSE  = 2'd0,
    SK_MANUAL = 2'd1,
    SK_LEVEL  = 2'd2
  } src_kind_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NSRC = 8,
  parameter logic [NSRC-1:0] LEVEL_SRC  = '0,
  parameter logic [NSRC-1:0] MANUAL_SRC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] w1c,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] flags
);
  import irq_flag_pkg::*;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam src_kind_e KIND = LEVEL_SRC[i]  ? SK_LEVEL  :
                                 MANUAL_SRC[i] ? SK_MANUAL : SK_PULSE;
    logic flag_q;
    logic flag_nx;

    if (KIND == SK_LEVEL) begin : g_level
      always_comb flag_nx = src_in[i];
    end else if (KIND == SK_MANUAL) begin : g_manual
      always_comb flag_nx = src_in[i] | (flag_q & ~w1c[i]);
    end else begin : g_pulse
      always_comb flag_nx = src_in[i] | (flag_q & ~w1c[i] & ~ack_clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_nx;
    end

    assign flags[i] = flag_q;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NSRC = 8,
  localparam int unsigned VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output logic [VW-1:0]   vec
);
  always_comb begin
    any = |pend;
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = VW'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic            ctrl_we,
  input  logic [NSRC-1:0] wdata,
  input  logic            take,
  input  logic            ret,
  output logic [NSRC-1:0] mask,
  output logic            gie
);
  logic [NSRC-1:0] mask_q;
  logic            gie_q;
  logic            gie_nx;
  logic            gie_en;

  always_comb begin
    gie_en = take | ret | ctrl_we;
    if (take)     gie_nx = 1'b0;
    else if (ret) gie_nx = 1'b1;
    else          gie_nx = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_en) gie_q <= gie_nx;
  end

  assign mask = mask_q;
  assign gie  = gie_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned NSRC = 8,
  parameter logic [NSRC-1:0] LEVEL_SRC  = NSRC'(1) << (NSRC - 1),
  parameter logic [NSRC-1:0] MANUAL_SRC = (NSRC > 1) ? (NSRC'(1) << (NSRC - 2)) : '0,
  localparam int unsigned VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_req,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic [VW-1:0]   irq_vec
);
  import irq_flag_pkg::*;

  logic [1:0]      rst_sync;
  logic            rst_q;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] mask;
  logic            gie;
  logic [NSRC-1:0] pend;
  logic            any_pend;
  logic [VW-1:0]   pick;
  logic            take;
  logic [NSRC-1:0] w1c;
  logic [NSRC-1:0] ack_clr;
  reg_sel_e        sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign sel     = reg_sel_e'(reg_addr);
  assign pend    = flags & mask;
  assign irq_req = gie & any_pend;
  assign irq_vec = pick;
  assign take    = irq_req & irq_ack;
  assign w1c     = (reg_wr && sel == RA_FLAG) ? reg_wdata : '0;
  assign ack_clr = take ? (NSRC'(1) << pick) : '0;

  irq_flag_bank #(
    .NSRC(NSRC), .LEVEL_SRC(LEVEL_SRC), .MANUAL_SRC(MANUAL_SRC)
  ) u_bank (
    .clk(clk), .rst_n(rst_q), .src_in(src_in),
    .w1c(w1c), .ack_clr(ack_clr), .flags(flags)
  );

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .pend(pend), .any(any_pend), .vec(pick)
  );

  irq_ctrl_regs #(.NSRC(NSRC)) u_ctrl (
    .clk(clk), .rst_n(rst_q),
    .mask_we(reg_wr && sel == RA_MASK),
    .ctrl_we(reg_wr && sel == RA_CTRL),
    .wdata(reg_wdata), .take(take), .ret(irq_ret),
    .mask(mask), .gie(gie)
  );

  always_comb begin
    unique case (sel)
      RA_FLAG: reg_rdata = flags;
      RA_MASK: reg_rdata = mask;
      RA_CTRL: reg_rdata = NSRC'(gie);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned NSRC = 8,
  parameter logic [NSRC-1:0] LEVEL_SRC = '0,
  localparam int unsigned VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_q,
  input logic [NSRC-1:0] src_in,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] mask,
  input logic            gie,
  input logic            irq_req,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic [VW-1:0]   irq_vec
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_q)
    irq_req |-> gie); // R5

  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_q)
    irq_req |-> (flags[irq_vec] && mask[irq_vec])); // R5

  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_req && irq_ack) |=> !gie); // R6

  AST_RET_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_ret && !(irq_req && irq_ack)) |=> gie); // R9

  AST_SET_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> ((flags & $past(src_in)) == $past(src_in))); // R2

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> ((flags & LEVEL_SRC) == ($past(src_in) & LEVEL_SRC))); // R8
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC), .LEVEL_SRC(LEVEL_SRC)) u_chk (
  .clk(clk), .rst_q(rst_q), .src_in(src_in), .flags(flags), .mask(mask),
  .gie(gie), .irq_req(irq_req), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .irq_vec(irq_vec)
);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  localparam int NSRC = 8;
  localparam logic [7:0] LVL = 8'h80;
  localparam logic [7:0] MAN = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_in = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic [2:0] irq_vec;

  always #4 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_vec(irq_vec)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_flag = '0;
  logic [7:0] m_mask = '0;
  logic       m_gie = 1'b0;
  logic [7:0] last_rd;
  logic       last_req;
  logic [2:0] last_vec;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] low_idx(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) low_idx = 3'(i);
    if (v == 0) low_idx = 3'd0;
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = m_flag;
      2'd1: m_read = m_mask;
      2'd2: m_read = {7'd0, m_gie};
      default: m_read = 8'd0;
    endcase
  endfunction

  task automatic cyc(input logic [7:0] s, input logic wr, input logic [1:0] a,
                     input logic [7:0] wd, input logic ak, input logic rt);
    logic m_req;
    logic take;
    logic [7:0] nf;
    @(negedge clk);
    src_in = s; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    irq_ack = ak; irq_ret = rt;
    #1;
    m_req = m_gie && ((m_flag & m_mask) != 0);
    last_rd = reg_rdata; last_req = irq_req; last_vec = irq_vec;
    chk(reg_rdata == m_read(a), "R10 rdata", reg_rdata, m_read(a));
    chk(irq_req == m_req, "R5 irq_req", irq_req, m_req);
    if (m_req) chk(irq_vec == low_idx(m_flag & m_mask), "R5 irq_vec",
                   irq_vec, low_idx(m_flag & m_mask));
    take = ak && m_req;
    for (int i = 0; i < 8; i++) begin
      if (LVL[i]) nf[i] = s[i];
      else nf[i] = s[i] | (m_flag[i] & ~(wr && a == 2'd0 && wd[i])
                   & ~(take && low_idx(m_flag & m_mask) == 3'(i) && !MAN[i]));
    end
    m_flag = nf;
    if (wr && a == 2'd1) m_mask = wd;
    if (take) m_gie = 1'b0;
    else if (rt) m_gie = 1'b1;
    else if (wr && a == 2'd2) m_gie = wd[0];
  endtask

  task automatic idle(input logic [1:0] a);
    cyc(8'h00, 1'b0, a, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    idle(2'd0); chk(last_rd == 8'h00 && !last_req, "R1 flags", last_rd, 0);
    idle(2'd1); chk(last_rd == 8'h00, "R1 mask", last_rd, 0);
    idle(2'd2); chk(last_rd == 8'h00, "R1 gie", last_rd, 0);

    // R2 set by pulse
    cyc(8'h0A, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    idle(2'd0); chk(last_rd == 8'h0A, "R2 set", last_rd, 8'h0A);
    // R3 writing zero keeps, writing one clears
    cyc(8'h00, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    idle(2'd0); chk(last_rd == 8'h0A, "R3 w0 keep", last_rd, 8'h0A);
    cyc(8'h00, 1'b1, 2'd0, 8'h02, 1'b0, 1'b0);
    idle(2'd0); chk(last_rd == 8'h08, "R3 w1 clear", last_rd, 8'h08);
    // R2 set beats clear
    cyc(8'h08, 1'b1, 2'd0, 8'h08, 1'b0, 1'b0);
    idle(2'd0); chk(last_rd == 8'h08, "R2 set wins", last_rd, 8'h08);
    // R4 read-modify-write hazard
    cyc(8'h01, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    idle(2'd0); rd = last_rd;
    cyc(8'h00, 1'b1, 2'd0, rd | 8'h00, 1'b0, 1'b0);
    idle(2'd0); chk(last_rd == 8'h00, "R4 rmw clears", last_rd, 0);

    // R5 priority
    cyc(8'h24, 1'b1, 2'd1, 8'hFF, 1'b0, 1'b0);
    idle(2'd0); chk(!last_req, "R5 no gie", last_req, 0);
    cyc(8'h00, 1'b1, 2'd2, 8'h01, 1'b0, 1'b0);
    idle(2'd2); chk(last_req && last_vec == 3'd2, "R5 lowest", last_vec, 2);
    // R6 ack drops gie, R7 auto clear
    cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    idle(2'd0); chk(last_rd == 8'h20 && !last_req, "R7 auto clear", last_rd, 8'h20);
    idle(2'd2); chk(last_rd == 8'h00, "R6 gie off", last_rd, 0);
    // R9 return re-enables
    cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
    idle(2'd0); chk(last_req && last_vec == 3'd5, "R9 ret", last_vec, 5);
    cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
    idle(2'd2); chk(last_rd == 8'h00, "R9 ack beats ret", last_rd, 0);

    // R7 manual source survives ack
    cyc(8'h40, 1'b1, 2'd0, 8'hFF, 1'b0, 1'b1);
    idle(2'd0); chk(last_req && last_vec == 3'd6, "R7 manual req", last_vec, 6);
    cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    idle(2'd0); chk(last_rd == 8'h40, "R7 manual kept", last_rd, 8'h40);
    cyc(8'h00, 1'b1, 2'd0, 8'h40, 1'b0, 1'b0);
    idle(2'd0); chk(last_rd == 8'h00, "R7 manual w1c", last_rd, 0);

    // R8 level source
    cyc(8'h80, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    cyc(8'h80, 1'b1, 2'd0, 8'h80, 1'b0, 1'b0);
    cyc(8'h80, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    chk(last_rd == 8'h80, "R8 level held", last_rd, 8'h80);
    idle(2'd0);
    idle(2'd0); chk(last_rd == 8'h00, "R8 level gone", last_rd, 0);

    // R10 address 3
    cyc(8'h00, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b0);
    idle(2'd3); chk(last_rd == 8'h00, "R10 addr3", last_rd, 0);
    idle(2'd1); chk(last_rd == 8'hFF, "R10 mask kept", last_rd, 8'hFF);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] s;
      s = 8'($urandom) & 8'($urandom) & 8'($urandom);
      s[7] = ($urandom % 4) != 0 ? src_in[7] : 1'($urandom);
      cyc(s, ($urandom % 4) == 0, 2'($urandom), 8'($urandom),
          ($urandom % 3) == 0, ($urandom % 6) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule